// File: doc/BRIEF.md
# Half-Rate Decimating Cascaded Moving-Average Filter

This block low-pass filters and decimates a stream of signed samples. It runs a cascade of identical moving-sum stages, where each stage adds up the most recent N accepted samples. After the last stage a single decimator keeps one result for every N/2 accepted samples. Each averaging window therefore yields two outputs, which leaves the response less distorted inside the pass band than decimating by the full N would.

The stage count is fixed when the block is built. The window length N is loaded at run time through a configuration strobe and can be any even value from 2 up to a build-time maximum. Loading a new N flushes the filter. Every stage has a gain of N, so the cascade's gain is N to the power of the stage count. The datapath is widened by that many bits, which keeps every result exact. Normalising the gain afterwards is left to downstream logic.

Top module: `hrcic_top`

## Requirements
- R1: After reset, out_valid and out_data are 0, all filter history is zero, and the window length is NMAX (default 16) until a configuration write changes it.
- R2: Every output equals the NSTAGE-fold cascade of moving sums over the last N accepted samples. Samples from before the most recent clear count as zero.
- R3: After the first output, exactly one output is produced for every N/2 accepted samples.
- R4: After a reset or a configuration write, the first output belongs to the (NSTAGE·N)-th accepted sample. Streams that are shorter than this produce no output.
- R5: A cycle with cfg_we high loads N from cfg_n and clears all history and the decimation phase. Any sample presented in that same cycle is dropped. cfg_n must be even and lie between 2 and NMAX.
- R6: The result for an accepted sample appears with out_valid high for exactly one cycle. It appears after NSTAGE+1 rising edges, counting the edge that accepts the sample as the first. out_data holds its value between pulses.
- R7: out_data is IN_W + NSTAGE·ceil(log2(NMAX)) bits wide (28 by default) in two's complement. Runs of full-scale positive (2047) or negative (-2048) input at N = NMAX come out exactly.
- R8: Cycles with in_valid low change no filter state. Gaps in the input stream therefore do not alter the outputs or the decimation phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load window length and clear the filter |
| cfg_n | input | $clog2(NMAX+1) | New window length N (even, 2..NMAX) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe per decimated result |
| out_data | output | OUT_W | Signed filtered result, held between strobes |

## Verification
On every cycle the assertions check four things:
- a configuration write is legal and silences the output in the following cycle;
- a stage accumulator never moves without an input sample;
- each output strobe follows a valid word from the last stage, and the output holds between strobes;
- emitted results stay exactly N/2 stage-outputs apart once warm-up is over.

Only the bench's scenarios show the rest:
- the arithmetic of the full cascade against an independent model;
- the length of the warm-up;
- the exact latency of each result;
- the flushing of history when N changes mid-stream;
- that a sample presented with a configuration write is dropped.

// File: rtl/hrcic_pkg.sv
package hrcic_pkg;

   // Width needed to hold the full cascade gain without overflow.
   function automatic int grown_width(input int in_w, input int nstage, input int nmax);
      return in_w + nstage * $clog2(nmax);
   endfunction

endpackage

// File: rtl/hrcic_stage.sv
module hrcic_stage #(
   parameter int W    = 28,
   parameter int NMAX = 16,
   parameter int NW   = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic [NW-1:0] n_cur,
   input  logic          in_valid,
   input  logic [W-1:0]  in_data,
   output logic          out_valid,
   output logic [W-1:0]  out_data
);
   localparam int IW = (NMAX > 2) ? $clog2(NMAX) : 1;

   logic [W-1:0]  dly [NMAX];
   logic [W-1:0]  acc;
   logic [IW-1:0] tap_idx;

   // sample that entered N accepted inputs ago
   assign tap_idx = IW'(n_cur - NW'(1));

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         acc       <= '0;
         out_valid <= 1'b0;
         for (int i = 0; i < NMAX; i++) dly[i] <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            acc    <= acc + in_data - dly[tap_idx];
            dly[0] <= in_data;
            for (int i = 1; i < NMAX; i++) dly[i] <= dly[i-1];
         end
      end
   end

   assign out_data = acc;

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !clr) |=> $stable(acc));

endmodule

// File: rtl/hrcic_decim.sv
module hrcic_decim #(
   parameter int W      = 28,
   parameter int NMAX   = 16,
   parameter int NSTAGE = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            clr,
   input  logic [$clog2(NMAX/2+1)-1:0]     half_n,
   input  logic [$clog2(NSTAGE*NMAX+1)-1:0] warm_len,
   input  logic                            in_valid,
   input  logic [W-1:0]                    in_data,
   output logic                            out_valid,
   output logic [W-1:0]                    out_data
);
   localparam int CW = $clog2(NMAX/2+1);
   localparam int WW = $clog2(NSTAGE*NMAX+1);

   logic          warm_done;
   logic [WW-1:0] warm_cnt;
   logic [CW-1:0] phase;
   logic          emit;

   assign emit = in_valid &&
                 (warm_done ? (phase == '0) : (warm_cnt == warm_len - WW'(1)));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_data <= '0;
      end else if (emit && !clr) begin
         out_data <= in_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         out_valid <= 1'b0;
         warm_done <= 1'b0;
         warm_cnt  <= '0;
         phase     <= '0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            warm_done <= 1'b1;
            phase     <= half_n - CW'(1);
         end else if (in_valid) begin
            if (warm_done) phase    <= phase - CW'(1);
            else           warm_cnt <= warm_cnt + WW'(1);
         end
      end
   end

   // Checker: stage outputs seen since the previous emitted result.
   logic [CW-1:0] gap_cnt;
   always_ff @(posedge clk) begin
      if (rst || clr)             gap_cnt <= '0;
      else if (emit)              gap_cnt <= '0;
      else if (in_valid && warm_done) gap_cnt <= gap_cnt + CW'(1);
   end

   // R3
   decim_spacing_chk: assert property (@(posedge clk) disable iff (rst || clr)
      (emit && warm_done) |-> (gap_cnt == half_n - CW'(1)));

   // R6
   out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));

   // R6
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data));

endmodule

// File: rtl/hrcic_top.sv
module hrcic_top
   import hrcic_pkg::*;
#(
   parameter  int IN_W   = 12,
   parameter  int NMAX   = 16,
   parameter  int NSTAGE = 4,
   localparam int NW     = $clog2(NMAX+1),
   localparam int OUT_W  = grown_width(IN_W, NSTAGE, NMAX)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic [NW-1:0]    cfg_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);
   localparam int CW = $clog2(NMAX/2+1);
   localparam int WW = $clog2(NSTAGE*NMAX+1);

   if (NMAX < 2 || (NMAX % 2) != 0) begin : g_bad_nmax
      $error("NMAX must be even and at least 2");
   end
   if (NSTAGE < 1) begin : g_bad_nstage
      $error("NSTAGE must be at least 1");
   end
   if (IN_W < 2) begin : g_bad_inw
      $error("IN_W must be at least 2");
   end

   logic [NW-1:0] n_q;
   logic [CW-1:0] half_n;
   logic [WW-1:0] warm_len;

   always_ff @(posedge clk) begin
      if (rst)         n_q <= NW'(NMAX);
      else if (cfg_we) n_q <= cfg_n;
   end

   assign half_n   = CW'(n_q >> 1);
   assign warm_len = WW'(n_q) * WW'(NSTAGE);

   logic [OUT_W-1:0] sd [NSTAGE+1];
   logic             sv [NSTAGE+1];

   assign sd[0] = {{(OUT_W-IN_W){in_data[IN_W-1]}}, in_data};
   assign sv[0] = in_valid && !cfg_we;

   for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
      hrcic_stage #(.W(OUT_W), .NMAX(NMAX), .NW(NW)) u_stage (
         .clk      (clk),
         .rst      (rst),
         .clr      (cfg_we),
         .n_cur    (n_q),
         .in_valid (sv[g]),
         .in_data  (sd[g]),
         .out_valid(sv[g+1]),
         .out_data (sd[g+1])
      );
   end

   hrcic_decim #(.W(OUT_W), .NMAX(NMAX), .NSTAGE(NSTAGE)) u_decim (
      .clk      (clk),
      .rst      (rst),
      .clr      (cfg_we),
      .half_n   (half_n),
      .warm_len (warm_len),
      .in_valid (sv[NSTAGE]),
      .in_data  (sd[NSTAGE]),
      .out_valid(out_valid),
      .out_data (out_data)
   );

   // R5
   cfg_legal_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_we |-> (cfg_n[0] == 1'b0 && cfg_n >= NW'(2) && cfg_n <= NW'(NMAX)));

   // R5
   clr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> !out_valid);

endmodule

// File: tb/hrcic_top_bench.sv
`timescale 1ns/1ps
module hrcic_top_bench;
   localparam int IN_W   = 12;
   localparam int NMAX   = 16;
   localparam int NSTAGE = 4;
   localparam int NW     = $clog2(NMAX+1);
   localparam int OUT_W  = IN_W + NSTAGE * $clog2(NMAX);
   localparam int MAXLEN = 128;
   localparam int NCASE  = 7;

   // window N, sample count, pattern, gap, expected output count
   localparam int TBL_N   [NCASE] = '{16,  2,  6, 16,  8,  16,  4};
   localparam int TBL_LEN [NCASE] = '{80, 20, 40, 60, 50, 100, 33};
   localparam int TBL_PAT [NCASE] = '{ 0,  4,  3,  4,  1,   2,  4};
   localparam int TBL_GAP [NCASE] = '{ 0,  0,  1,  0,  0,   0,  1};
   localparam int TBL_CNT [NCASE] = '{ 3, 13,  6,  0,  5,   5,  9};

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             cfg_we = 1'b0;
   logic [NW-1:0]    cfg_n = '0;
   logic             in_valid = 1'b0;
   logic [IN_W-1:0]  in_data = '0;
   logic             out_valid;
   logic [OUT_W-1:0] out_data;

   always #2.5 clk = ~clk;

   hrcic_top #(.IN_W(IN_W), .NMAX(NMAX), .NSTAGE(NSTAGE)) u_hrcic_top (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_n(cfg_n),
      .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   logic [OUT_W-1:0] cap_val [1024];
   int               cap_cyc [1024];
   int               cap_n = 0;

   always @(negedge clk) begin
      if (out_valid && cap_n < 1024) begin
         cap_val[cap_n] = out_data;
         cap_cyc[cap_n] = cyc;
         cap_n = cap_n + 1;
      end
   end

   longint lvl [0:NSTAGE][1:MAXLEN];
   int     drive_cyc [1:MAXLEN];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int pat_val(input int p, input int i);
      longint v;
      case (p)
         0: return ((i * 37) % 4096) - 2048;
         1: return 2047;
         2: return -2048;
         3: return (i % 2 == 1) ? 2047 : -2048;
         5: return 1;
         default: begin
            v = (longint'(i) * 64'd1103515245 + 64'd12345) & 64'hFFFF_FFFF;
            return int'((v >> 8) & 64'd4095) - 2048;
         end
      endcase
   endfunction

   task automatic build_model(input int n, input int m);
      for (int k = 1; k <= NSTAGE; k++) begin
         for (int i = 1; i <= m; i++) begin
            longint s = 0;
            for (int j = 0; j < n; j++) if (i - j >= 1) s += lvl[k-1][i-j];
            lvl[k][i] = s;
         end
      end
   endtask

   task automatic run_case(input int n, input int m, input int p, input int gap,
                           input bit do_cfg, input int exp_cnt, input string tag);
      int base;
      int got;
      int lim;
      base = cap_n;
      if (do_cfg) begin
         @(negedge clk);
         cfg_we = 1'b1;
         cfg_n  = NW'(n);
         @(negedge clk);
         cfg_we = 1'b0;
      end
      for (int i = 1; i <= m; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = IN_W'(pat_val(p, i));
         lvl[0][i] = longint'(pat_val(p, i));
         drive_cyc[i] = cyc;
         if (gap != 0) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (NSTAGE + 4) @(negedge clk);
      build_model(n, m);
      got = cap_n - base;
      chk(got == exp_cnt, tag, got, exp_cnt);
      lim = (got < exp_cnt) ? got : exp_cnt;
      for (int i = 0; i < lim; i++) begin
         int mi = NSTAGE * n + i * (n / 2);
         chk(cap_val[base+i] == OUT_W'(lvl[NSTAGE][mi]), "R2 cascade value",
             longint'($signed(cap_val[base+i])), lvl[NSTAGE][mi]);
         chk(cap_cyc[base+i] == drive_cyc[mi] + NSTAGE + 1, "R6 latency",
             cap_cyc[base+i], drive_cyc[mi] + NSTAGE + 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      chk(out_data == '0, "R1 out_data after reset", longint'($signed(out_data)), 0);
      rst = 1'b0;
      @(negedge clk);
      // R1 default window NMAX without any configuration write; R4 warm-up
      run_case(NMAX, 72, 0, 0, 1'b0, 2, "R1 default window count");
      // table walk: R3 spacing, R4 short stream, R7 full-scale, R8 gaps
      for (int t = 0; t < NCASE; t++) begin
         run_case(TBL_N[t], TBL_LEN[t], TBL_PAT[t], TBL_GAP[t], 1'b1, TBL_CNT[t],
                  (t == 3) ? "R4 no output before warm-up" :
                  (TBL_GAP[t] != 0) ? "R8 gapped stream count" :
                  (TBL_PAT[t] == 1 || TBL_PAT[t] == 2) ? "R7 full-scale count" :
                  "R3 output count");
      end
      // R7 exact extreme values at N = NMAX
      run_case(NMAX, 64, 2, 0, 1'b1, 1, "R7 min full-scale count");
      chk(cap_val[cap_n-1] == OUT_W'(-134217728), "R7 min value",
          longint'($signed(cap_val[cap_n-1])), -134217728);
      run_case(NMAX, 64, 1, 0, 1'b1, 1, "R7 max full-scale count");
      chk(cap_val[cap_n-1] == OUT_W'(134152192), "R7 max value",
          longint'($signed(cap_val[cap_n-1])), 134152192);
      // R5 sample presented with the configuration write is dropped
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_n = NW'(2);
      in_valid = 1'b1;
      in_data = IN_W'(2047);
      @(negedge clk);
      cfg_we = 1'b0;
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R5 quiet after config", out_valid, 0);
      run_case(2, 8, 5, 0, 1'b0, 1, "R5 config-cycle sample dropped");
      chk(cap_val[cap_n-1] == OUT_W'(16), "R5 value after drop",
          longint'($signed(cap_val[cap_n-1])), 16);
      // R6 output held between strobes
      chk(out_data == cap_val[cap_n-1], "R6 hold after last strobe",
          longint'($signed(out_data)), longint'($signed(cap_val[cap_n-1])));
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule